// File: doc/BRIEF.md
# Variable-Length Instruction Byte Assembler

This block sits between a byte-wide code memory read port and an instruction decoder. It takes code bytes one at a time through a valid/ready handshake. From the first byte of each instruction (the opcode) it works out whether the instruction is one, two or three bytes long. It then collects the operand bytes that follow and presents the whole instruction at once: the opcode, an 8-bit immediate, a 16-bit word built from two bytes stored low byte first, and a length tag.

A 16-bit fetch counter gives the address of the next byte to be read. It advances by one for every byte accepted. A flush input loads a new fetch address, for example after a taken branch. The flush throws away anything partly collected or still waiting, and the next accepted byte is treated as an opcode. A completed instruction stays on the output until the consumer takes it. While it waits, no further code bytes are accepted.

Top module: `insn_byte_asm`

## Requirements
- R1: After reset, `outValid` is 0, `fetchAddr` equals the reset address (0 by default) and `inReady` is 1.
- R2: An opcode whose bits [7:6] are 01 or 10 yields a one-byte instruction.
- R3: For an opcode with bits [7:6] = 00, the length depends on bits [2:0]. Code 001 gives three bytes and code 110 gives two bytes. Code 010 gives three bytes when bit 5 is 1 and one byte when bit 5 is 0. Every other code gives one byte.
- R4: For an opcode with bits [7:6] = 11, bits [2:0] of 010, 100 or 101 give three bytes, and 110 gives two bytes. For code 011, opcode C3h gives three bytes, D3h and DBh give two bytes, and any other opcode gives one byte. Codes 000, 001 and 111 give one byte.
- R5: `outImm8` holds the second byte of the instruction. Any operand byte the instruction does not have reads as zero on `outImm8` and `outWord16`.
- R6: `outWord16` is {third byte, second byte}. For example, C3h 00h 62h gives 6200h.
- R7: `outLen` encodes the instruction length as 1, 2 or 3.
- R8: Each accepted byte (`inValid` and `inReady` both high at a clock edge) adds one to `fetchAddr`, wrapping at 16 bits.
- R9: `outValid` rises in the cycle after the last byte of an instruction is accepted. It then stays high with every output field stable, and `inReady` stays low, until the cycle after `outReady` is seen high.
- R10: While `flushValid` is high, `inReady` is 0. On the next cycle `fetchAddr` equals `flushAddr` and `outValid` is 0. Any partial or waiting instruction is dropped, and the next accepted byte is taken as an opcode.
- R11: With `inValid` low and no flush, `fetchAddr` and the collection state do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 8 | Code byte from memory |
| inValid | input | 1 | Code byte present |
| inReady | output | 1 | Block takes the byte this cycle |
| flushValid | input | 1 | Redirect fetching |
| flushAddr | input | 16 | New fetch address |
| fetchAddr | output | 16 | Address of the next byte to fetch |
| outValid | output | 1 | Complete instruction present |
| outReady | input | 1 | Consumer takes the instruction |
| outOpcode | output | 8 | Opcode byte |
| outImm8 | output | 8 | Second byte, or zero |
| outWord16 | output | 16 | {third, second} byte, absent bytes zero |
| outLen | output | 2 | Instruction length, 1 to 3 |

## Verification
The results fall due at different times. `inReady` depends on `flushValid` within the same cycle, so it is checked in the cycle where the inputs are driven. `fetchAddr` and the flush redirect change one clock edge after the byte or flush that causes them. `outValid` and the instruction fields appear one edge after the final byte is accepted, and they clear one edge after `outReady`. The bench drives inputs on the falling edge, lets them settle, and compares every output against a reference model that it advances at each rising edge. Each comparison therefore sees exactly the state that the counted registers have reached.

// File: rtl/insn_asm_pkg.sv
package insn_asm_pkg;
  localparam int BYTE_W = 8;
  localparam int OPND_N = 2;
  localparam int WORD_W = BYTE_W * OPND_N;

  typedef logic [1:0] len_t;

  typedef enum logic [1:0] {
    PH_OPC  = 2'd0,
    PH_OP1  = 2'd1,
    PH_OP2  = 2'd2,
    PH_HOLD = 2'd3
  } phase_t;

  typedef struct packed {
    logic              loadOp;
    logic [OPND_N-1:0] loadOpnd;
    logic              incAddr;
    logic              loadAddr;
  } dp_strobe_t;

  function automatic len_t insnLength(input logic [BYTE_W-1:0] op);
    len_t len;
    len = 2'd1;
    unique case (op[7:6])
      2'b00: begin
        unique case (op[2:0])
          3'b001:  len = 2'd3;
          3'b110:  len = 2'd2;
          3'b010:  len = op[5] ? 2'd3 : 2'd1;
          default: len = 2'd1;
        endcase
      end
      2'b11: begin
        unique case (op[2:0])
          3'b010, 3'b100, 3'b101: len = 2'd3;
          3'b110:                 len = 2'd2;
          3'b011: begin
            if (op == 8'hC3)                      len = 2'd3;
            else if (op == 8'hD3 || op == 8'hDB)  len = 2'd2;
            else                                  len = 2'd1;
          end
          default: len = 2'd1;
        endcase
      end
      default: len = 2'd1;
    endcase
    return len;
  endfunction
endpackage

// File: rtl/insn_asm_ctrl.sv
module insn_asm_ctrl
  import insn_asm_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [BYTE_W-1:0] inData,
  input  logic              flushValid,
  input  logic              outReady,
  output logic              inReady,
  output logic              outValid,
  output len_t              outLen,
  output dp_strobe_t        st
);
  phase_t phase;
  len_t   lenReg;
  len_t   newLen;
  logic   accept;

  always_comb begin
    inReady     = (phase != PH_HOLD) && !flushValid;
    accept      = inValid && inReady;
    newLen      = insnLength(inData);
    st          = '0;
    st.loadAddr = flushValid;
    st.incAddr  = accept;
    st.loadOp   = accept && (phase == PH_OPC);
    st.loadOpnd[0] = accept && (phase == PH_OP1);
    st.loadOpnd[1] = accept && (phase == PH_OP2);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase  <= PH_OPC;
      lenReg <= 2'd1;
    end else if (flushValid) begin
      phase <= PH_OPC;
    end else begin
      unique case (phase)
        PH_OPC: if (accept) begin
          lenReg <= newLen;
          phase  <= (newLen == 2'd1) ? PH_HOLD : PH_OP1;
        end
        PH_OP1: if (accept) phase <= (lenReg == 2'd2) ? PH_HOLD : PH_OP2;
        PH_OP2: if (accept) phase <= PH_HOLD;
        PH_HOLD: if (outReady) phase <= PH_OPC;
        default: phase <= PH_OPC;
      endcase
    end
  end

  assign outValid = (phase == PH_HOLD);
  assign outLen   = lenReg;

  AST_LEN_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    outValid |-> (lenReg != 2'd0)); // R7
  AST_HOLD_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !flushValid) |=> (outValid && $stable(lenReg))); // R9
endmodule

// File: rtl/insn_asm_dpath.sv
module insn_asm_dpath
  import insn_asm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        st,
  input  logic [BYTE_W-1:0] inData,
  input  logic [ADDR_W-1:0] flushAddr,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic [BYTE_W-1:0] outOpcode,
  output logic [BYTE_W-1:0] outImm8,
  output logic [WORD_W-1:0] outWord16
);
  always_ff @(posedge clk) begin
    if (!rstN)            fetchAddr <= RESET_ADDR;
    else if (st.loadAddr) fetchAddr <= flushAddr;
    else if (st.incAddr)  fetchAddr <= fetchAddr + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)          outOpcode <= '0;
    else if (st.loadOp) outOpcode <= inData;
  end

  for (genvar i = 0; i < OPND_N; i++) begin : g_opnd
    logic [BYTE_W-1:0] q;
    always_ff @(posedge clk) begin
      if (!rstN)               q <= '0;
      else if (st.loadOp)      q <= '0;
      else if (st.loadOpnd[i]) q <= inData;
    end
    assign outWord16[i*BYTE_W +: BYTE_W] = q;
  end

  assign outImm8 = outWord16[BYTE_W-1:0];

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({st.loadOp, st.loadOpnd})); // R5
  AST_FLUSH_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    st.loadAddr |=> (fetchAddr == $past(flushAddr))); // R10
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (st.incAddr && !st.loadAddr) |=> (fetchAddr == ADDR_W'($past(fetchAddr) + 1'b1))); // R8
endmodule

// File: rtl/insn_byte_asm.sv
module insn_byte_asm
  import insn_asm_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter logic [ADDR_W-1:0] RESET_ADDR = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [7:0]        inData,
  input  logic              inValid,
  output logic              inReady,
  input  logic              flushValid,
  input  logic [ADDR_W-1:0] flushAddr,
  output logic [ADDR_W-1:0] fetchAddr,
  output logic              outValid,
  input  logic              outReady,
  output logic [7:0]        outOpcode,
  output logic [7:0]        outImm8,
  output logic [15:0]       outWord16,
  output logic [1:0]        outLen
);
  dp_strobe_t st;

  insn_asm_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .inValid    (inValid),
    .inData     (inData),
    .flushValid (flushValid),
    .outReady   (outReady),
    .inReady    (inReady),
    .outValid   (outValid),
    .outLen     (outLen),
    .st         (st)
  );

  insn_asm_dpath #(
    .ADDR_W     (ADDR_W),
    .RESET_ADDR (RESET_ADDR)
  ) dpath_i (
    .clk       (clk),
    .rstN      (rstN),
    .st        (st),
    .inData    (inData),
    .flushAddr (flushAddr),
    .fetchAddr (fetchAddr),
    .outOpcode (outOpcode),
    .outImm8   (outImm8),
    .outWord16 (outWord16)
  );

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !flushValid) |=>
      (outValid && !inReady && $stable(outOpcode) && $stable(outWord16) && $stable(fetchAddr))); // R9
  AST_ONEBYTE_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outLen == 2'd1) |-> (outWord16 == 16'h0000)); // R5
  AST_FLUSH_DROP: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> !outValid); // R10
  AST_IDLE_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    (!inValid && !flushValid) |=> $stable(fetchAddr)); // R11
endmodule

// File: tb/insn_byte_asm_tb_top.sv
`timescale 1ns/1ps
module insn_byte_asm_tb_top;
  logic        clk = 1'b0;
  logic        rstN;
  logic [7:0]  inData;
  logic        inValid;
  logic        inReady;
  logic        flushValid;
  logic [15:0] flushAddr;
  logic [15:0] fetchAddr;
  logic        outValid;
  logic        outReady;
  logic [7:0]  outOpcode;
  logic [7:0]  outImm8;
  logic [15:0] outWord16;
  logic [1:0]  outLen;

  int total = 0;
  int bad   = 0;
  bit doneFlag = 0;

  // reference model state
  int          mPh;
  bit          mValid;
  logic [7:0]  mOp, mB1, mB2;
  int          mLen;
  logic [15:0] mAddr;

  always #10 clk = ~clk;

  insn_byte_asm dut_i (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inReady(inReady),
    .flushValid(flushValid), .flushAddr(flushAddr), .fetchAddr(fetchAddr),
    .outValid(outValid), .outReady(outReady), .outOpcode(outOpcode),
    .outImm8(outImm8), .outWord16(outWord16), .outLen(outLen)
  );

  function automatic int expLen(logic [7:0] op);
    logic [1:0] g = op[7:6];
    logic [2:0] f = op[2:0];
    if (g == 2'b01 || g == 2'b10) return 1;
    if (g == 2'b00) begin
      if (f == 3'd1) return 3;
      if (f == 3'd6) return 2;
      if (f == 3'd2) return op[5] ? 3 : 1;
      return 1;
    end
    if (op == 8'hC3) return 3;
    if (op == 8'hD3 || op == 8'hDB) return 2;
    if (f == 3'd2 || f == 3'd4 || f == 3'd5) return 3;
    if (f == 3'd6) return 2;
    return 1;
  endfunction

  function automatic string lenTag(logic [7:0] op);
    if (op[7:6] == 2'b00) return "R3";
    if (op[7:6] == 2'b11) return "R4";
    return "R2";
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, compare, advance the model at the rising edge
  task automatic step(input bit iv, input logic [7:0] d, input bit ordy,
                      input bit fl, input logic [15:0] fa, output bit acc);
    bit expRdy;
    inValid = iv; inData = d; outReady = ordy; flushValid = fl; flushAddr = fa;
    #1;
    expRdy = !mValid && !fl;
    chk(inReady == expRdy, fl ? "R10" : "R9", inReady, expRdy);
    chk(outValid == mValid, "R9", outValid, mValid);
    chk(fetchAddr == mAddr, (iv || fl) ? "R8" : "R11", fetchAddr, mAddr);
    if (mValid) begin
      chk(outOpcode == mOp, "R9", outOpcode, mOp);
      chk(int'(outLen) == mLen, "R7", outLen, mLen);
      chk(int'(outLen) == expLen(mOp), lenTag(mOp), outLen, expLen(mOp));
      chk(outImm8 == mB1, "R5", outImm8, mB1);
      chk(outWord16 == {mB2, mB1}, "R6", outWord16, {mB2, mB1});
    end
    acc = iv && expRdy;
    @(posedge clk);
    if (fl) begin
      mAddr = fa; mValid = 0; mPh = 0;
    end else if (mValid) begin
      if (ordy) mValid = 0;
    end else if (iv) begin
      mAddr = mAddr + 16'd1;
      case (mPh)
        0: begin
          mOp = d; mB1 = 8'h00; mB2 = 8'h00; mLen = expLen(d);
          if (mLen == 1) mValid = 1; else mPh = 1;
        end
        1: begin
          mB1 = d;
          if (mLen == 2) begin mValid = 1; mPh = 0; end else mPh = 2;
        end
        default: begin mB2 = d; mValid = 1; mPh = 0; end
      endcase
    end
    @(negedge clk);
  endtask

  task automatic feed(input logic [7:0] d);
    bit acc;
    acc = 0;
    while (!acc) step(1'b1, d, 1'b0, 1'b0, 16'h0, acc);
  endtask

  task automatic drain(input int n);
    bit acc;
    for (int i = 0; i < n; i++) step(1'b0, 8'h00, 1'b1, 1'b0, 16'h0, acc);
  endtask

  task automatic finishRun();
    if (!doneFlag) begin
      doneFlag = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 20);
    total++; bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    finishRun();
  end

  initial begin
    bit acc;
    void'($urandom(32'h5EED_0085));
    rstN = 0; inValid = 0; inData = 0; outReady = 0; flushValid = 0; flushAddr = 0;
    mPh = 0; mValid = 0; mOp = 0; mB1 = 0; mB2 = 0; mLen = 1; mAddr = 16'h0000;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    #1;
    chk(outValid == 1'b0, "R1", outValid, 0);
    chk(fetchAddr == 16'h0000, "R1", fetchAddr, 0);
    chk(inReady == 1'b1, "R1", inReady, 1);

    // R6: jump with low-byte-first address, held while consumer stalls (R9)
    feed(8'hC3); feed(8'h00); feed(8'h62);
    step(1'b1, 8'h11, 1'b0, 1'b0, 16'h0, acc);
    chk(outWord16 == 16'h6200, "R6", outWord16, 16'h6200);
    chk(acc == 0, "R9", acc, 0);
    drain(2);
    // R5: two-byte immediate
    feed(8'h06); feed(8'h08); drain(2);
    // R3: load/store direct vs indirect
    feed(8'h3A); feed(8'h34); feed(8'h12); drain(2);
    feed(8'h0A); drain(2);
    feed(8'h21); feed(8'hCD); feed(8'hAB); drain(2);
    // R4: port I/O, other 011 code, immediate ALU, return, call
    feed(8'hD3); feed(8'h40); drain(2);
    feed(8'hDB); feed(8'h41); drain(2);
    feed(8'hCB); drain(2);
    feed(8'hC6); feed(8'h05); drain(2);
    feed(8'hC9); drain(2);
    feed(8'hCD); feed(8'h00); feed(8'h80); drain(2);
    // R2: move and ALU
    feed(8'h41); drain(2);
    feed(8'h80); drain(2);
    // R10: flush in middle of a three-byte instruction
    feed(8'hC3); feed(8'h55);
    step(1'b1, 8'h77, 1'b0, 1'b1, 16'hFFFF, acc);
    chk(fetchAddr == 16'hFFFF, "R10", fetchAddr, 16'hFFFF);
    feed(8'h78); drain(2);
    // R8: wrap was exercised above; R11: idle cycles
    drain(4);
    chk(fetchAddr == mAddr, "R11", fetchAddr, mAddr);
    // R10: flush while an instruction waits
    feed(8'h47);
    step(1'b0, 8'h00, 1'b0, 1'b1, 16'h2000, acc);
    chk(outValid == 1'b0, "R10", outValid, 0);

    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 4) != 0, 8'($urandom), ($urandom % 3) != 0,
           ($urandom % 40) == 0, 16'($urandom), acc);
    end
    finishRun();
  end
endmodule